// File: doc/BRIEF.md
# Boundary-Scan Test Access Port for a Synchronous Memory

This block is the serial test port of a synchronous memory die. A 16-state controller advances on the rising edge of the test clock, steered by the mode-select input, and routes the serial data input through one of four shift paths to the serial data output. The paths are a 3-bit instruction register, a 1-bit bypass cell, a 32-bit identification register and a boundary register whose length is a parameter. The test clock also acts as the block's clock, and an asynchronous active-high reset forces the controller home.

The device pins are modelled as two parallel vectors. A capture vector carries the pin states into the boundary register. An update vector, held in a falling-edge latch, drives the pins whenever the external-test opcode is active. A second control line tells the pad ring to float every memory output while the float-and-sample opcode is active.

Board test software normally preloads a pattern with the sample opcode and then switches to external test so that the pattern appears on the pins. It reads the identification code, which is the default instruction, or short-circuits the die through the bypass cell.

Top module: `jtag_tap`

## Requirements
- R1: After `trst` is asserted, and whenever the controller passes through Test-Logic-Reset, the active instruction is IDCODE (binary 001). A DR scan from reset then returns the identification word.
- R2: Holding `tms` high for five consecutive rising edges of `tck` reaches Test-Logic-Reset from any state. This reload of IDCODE discards a previously loaded instruction.
- R3: Capture-IR loads binary 001 into the instruction shifter, whose bit 0 is shifted out first. The new opcode takes effect on the falling edge of `tck` in Update-IR. Opcode bit 0 is the first bit shifted in.
- R4: Opcodes 011, 101, 110 and 111 select the 1-bit bypass cell. The cell captures 0, so the output stream is the input delayed by one bit after a leading 0.
- R5: Under IDCODE (001), Capture-DR loads the 32-bit `ID_VALUE` with bit 0 forced to 1, and that bit leaves first.
- R6: Under opcodes 000, 010 and 100, Capture-DR loads the boundary register with `pin_capture` where `PIN_MASK` is 1 and with `CELL_DEFAULT` where it is 0. The register is `BSR_LEN` bits long and shifts bit 0 out first.
- R7: While opcode 010 is active, `force_hiz` is 1 and `drive_from_bsr` is 0. The boundary register is the selected path.
- R8: `bsr_out` changes only on the falling edge in Update-DR while a boundary opcode (000, 010 or 100) is active. `drive_from_bsr` is 1 exactly while opcode 000 is active, and it presents the already preloaded `bsr_out`.
- R9: `tdo_oe` is 1 only while the controller is in Shift-DR or Shift-IR. `tdo` changes only on falling edges of `tck`.
- R10: Asserting `trst` at any time immediately returns the instruction to IDCODE, which clears `force_hiz` and `drive_from_bsr`, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst | input | 1 | Asynchronous active-high port reset |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in |
| pin_capture | input | BSR_LEN | Parallel pin states for Capture-DR |
| tdo | output | 1 | Serial data out, changes on falling `tck` |
| tdo_oe | output | 1 | Output enable for `tdo` |
| bsr_out | output | BSR_LEN | Boundary update latch contents |
| drive_from_bsr | output | 1 | Pins take `bsr_out` (external test active) |
| force_hiz | output | 1 | Float all memory outputs |

## Verification
The bench walks through every bypass-aliased opcode. If an opcode were decoded as a boundary or ID path, the one-bit delay would be replaced by a long captured word. A preload followed by a switch to external test shows whether the update latch is wrongly reloaded by an instruction scan or is moved before Update-DR. Two further scans separate pin cells from default cells and show a forced-low or unforced ID bit 0. The bench samples `tdo` just after a rising edge to catch a rising-edge output stage. Escapes from a mid-scan state, by five ones or by an asynchronous reset, expose a controller that fails to reach reset or an instruction that survives it.

// File: rtl/jtag_tap_pkg.sv
`timescale 1ns/1ps
package jtag_tap_pkg;

    localparam int IR_W = 3;
    localparam int ID_W = 32;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    typedef enum logic [IR_W-1:0] {
        OP_EXTEST = 3'b000,
        OP_IDCODE = 3'b001,
        OP_FLOAT  = 3'b010,
        OP_RSVA   = 3'b011,
        OP_SAMPLE = 3'b100,
        OP_PRIV   = 3'b101,
        OP_RSVB   = 3'b110,
        OP_BYPASS = 3'b111
    } tap_op_e;

    typedef enum logic [1:0] {
        SEL_BYP,
        SEL_ID,
        SEL_BSR
    } dr_sel_e;

    localparam logic [IR_W-1:0] IR_CAPTURE_PAT = 3'b001;

    function automatic tap_state_e tap_next(input tap_state_e st, input logic m);
        tap_state_e n;
        case (st)
            ST_RESET:  n = m ? ST_RESET  : ST_IDLE;
            ST_IDLE:   n = m ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: n = m ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: n = m ? ST_EX1_DR : ST_SHF_DR;
            ST_SHF_DR: n = m ? ST_EX1_DR : ST_SHF_DR;
            ST_EX1_DR: n = m ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: n = m ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: n = m ? ST_UPD_DR : ST_SHF_DR;
            ST_UPD_DR: n = m ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: n = m ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: n = m ? ST_EX1_IR : ST_SHF_IR;
            ST_SHF_IR: n = m ? ST_EX1_IR : ST_SHF_IR;
            ST_EX1_IR: n = m ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: n = m ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: n = m ? ST_UPD_IR : ST_SHF_IR;
            ST_UPD_IR: n = m ? ST_SEL_DR : ST_IDLE;
            default:   n = ST_RESET;
        endcase
        return n;
    endfunction

    function automatic dr_sel_e dr_pick(input tap_op_e op);
        dr_sel_e s;
        case (op)
            OP_EXTEST, OP_FLOAT, OP_SAMPLE: s = SEL_BSR;
            OP_IDCODE:                      s = SEL_ID;
            default:                        s = SEL_BYP;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/jtag_tap_fsm.sv
`timescale 1ns/1ps
module jtag_tap_fsm
    import jtag_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst,
    input  logic       tms,
    output tap_state_e state
);

    always_ff @(posedge tck or posedge trst) begin
        if (trst) begin
            state <= ST_RESET;
        end else begin
            state <= tap_next(state, tms);
        end
    end

endmodule

// File: rtl/jtag_tap_ir.sv
`timescale 1ns/1ps
module jtag_tap_ir
    import jtag_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst,
    input  tap_state_e state,
    input  logic       tdi,
    output tap_op_e    ir,
    output logic       ir_tdo
);

    logic [IR_W-1:0] ir_sr;

    // capture / shift on the rising edge
    always_ff @(posedge tck or posedge trst) begin
        if (trst) begin
            ir_sr <= '0;
        end else if (state == ST_CAP_IR) begin
            ir_sr <= IR_CAPTURE_PAT;
        end else if (state == ST_SHF_IR) begin
            ir_sr <= {tdi, ir_sr[IR_W-1:1]};
        end
    end

    // active opcode moves on the falling edge
    always_ff @(negedge tck or posedge trst) begin
        if (trst) begin
            ir <= OP_IDCODE;
        end else if (state == ST_RESET) begin
            ir <= OP_IDCODE;
        end else if (state == ST_UPD_IR) begin
            ir <= tap_op_e'(ir_sr);
        end
    end

    assign ir_tdo = ir_sr[0];

endmodule

// File: rtl/jtag_tap_dr.sv
`timescale 1ns/1ps
module jtag_tap_dr
    import jtag_tap_pkg::*;
#(
    parameter int                   BSR_LEN      = 8,
    parameter logic [ID_W-1:0]      ID_VALUE     = 32'h1357_9BD4,
    parameter logic [BSR_LEN-1:0]   PIN_MASK     = '1,
    parameter logic [BSR_LEN-1:0]   CELL_DEFAULT = '0
) (
    input  logic               tck,
    input  logic               trst,
    input  tap_state_e         state,
    input  tap_op_e            ir,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] pin_capture,
    output logic               dr_tdo,
    output logic [BSR_LEN-1:0] bsr_out
);

    localparam logic [ID_W-1:0] ID_WORD = {ID_VALUE[ID_W-1:1], 1'b1};

    dr_sel_e            sel;
    logic               byp_q;
    logic [ID_W-1:0]    id_sr;
    logic [BSR_LEN-1:0] bsr_sr;
    logic [BSR_LEN-1:0] bsr_cap;

    assign sel     = dr_pick(ir);
    assign bsr_cap = (pin_capture & PIN_MASK) | (CELL_DEFAULT & ~PIN_MASK);

    always_ff @(posedge tck or posedge trst) begin
        if (trst) begin
            byp_q  <= 1'b0;
            id_sr  <= '0;
            bsr_sr <= '0;
        end else if (state == ST_CAP_DR) begin
            case (sel)
                SEL_ID:  id_sr  <= ID_WORD;
                SEL_BSR: bsr_sr <= bsr_cap;
                default: byp_q  <= 1'b0;
            endcase
        end else if (state == ST_SHF_DR) begin
            case (sel)
                SEL_ID:  id_sr  <= {tdi, id_sr[ID_W-1:1]};
                SEL_BSR: bsr_sr <= {tdi, bsr_sr[BSR_LEN-1:1]};
                default: byp_q  <= tdi;
            endcase
        end
    end

    // boundary update latch, falling edge of Update-DR
    always_ff @(negedge tck or posedge trst) begin
        if (trst) begin
            bsr_out <= '0;
        end else if (state == ST_UPD_DR && sel == SEL_BSR) begin
            bsr_out <= bsr_sr;
        end
    end

    always_comb begin
        case (sel)
            SEL_ID:  dr_tdo = id_sr[0];
            SEL_BSR: dr_tdo = bsr_sr[0];
            default: dr_tdo = byp_q;
        endcase
    end

endmodule

// File: rtl/jtag_tap.sv
`timescale 1ns/1ps
module jtag_tap
    import jtag_tap_pkg::*;
#(
    parameter int                   BSR_LEN      = 8,
    parameter logic [ID_W-1:0]      ID_VALUE     = 32'h1357_9BD4,
    parameter logic [BSR_LEN-1:0]   PIN_MASK     = 8'hB6,
    parameter logic [BSR_LEN-1:0]   CELL_DEFAULT = 8'h41
) (
    input  logic               tck,
    input  logic               trst,
    input  logic               tms,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] pin_capture,
    output logic               tdo,
    output logic               tdo_oe,
    output logic [BSR_LEN-1:0] bsr_out,
    output logic               drive_from_bsr,
    output logic               force_hiz
);

    tap_state_e state_q;
    tap_op_e    ir_q;
    logic       ir_bit;
    logic       dr_bit;

    jtag_tap_fsm u_fsm (
        .tck   (tck),
        .trst  (trst),
        .tms   (tms),
        .state (state_q)
    );

    jtag_tap_ir u_ir (
        .tck    (tck),
        .trst   (trst),
        .state  (state_q),
        .tdi    (tdi),
        .ir     (ir_q),
        .ir_tdo (ir_bit)
    );

    jtag_tap_dr #(
        .BSR_LEN      (BSR_LEN),
        .ID_VALUE     (ID_VALUE),
        .PIN_MASK     (PIN_MASK),
        .CELL_DEFAULT (CELL_DEFAULT)
    ) u_dr (
        .tck         (tck),
        .trst        (trst),
        .state       (state_q),
        .ir          (ir_q),
        .tdi         (tdi),
        .pin_capture (pin_capture),
        .dr_tdo      (dr_bit),
        .bsr_out     (bsr_out)
    );

    // serial output stage on the falling edge
    always_ff @(negedge tck or posedge trst) begin
        if (trst) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo    <= (state_q == ST_SHF_IR) ? ir_bit : dr_bit;
            tdo_oe <= (state_q == ST_SHF_IR) || (state_q == ST_SHF_DR);
        end
    end

    assign drive_from_bsr = (ir_q == OP_EXTEST);
    assign force_hiz      = (ir_q == OP_FLOAT);

endmodule

// File: rtl/jtag_tap_chk.sv
`timescale 1ns/1ps
module jtag_tap_chk
    import jtag_tap_pkg::*;
#(
    parameter int BSR_LEN = 8
) (
    input logic               tck,
    input logic               trst,
    input logic               tms,
    input tap_state_e         state,
    input tap_op_e            ir,
    input logic               tdo_oe,
    input logic [BSR_LEN-1:0] bsr_out,
    input logic               drive_from_bsr,
    input logic               force_hiz
);

    logic [2:0] ones;

    always_ff @(posedge tck or posedge trst) begin
        if (trst) begin
            ones <= '0;
        end else if (!tms) begin
            ones <= '0;
        end else if (ones != 3'd7) begin
            ones <= ones + 3'd1;
        end
    end

    AST_RESET_GIVES_IDCODE: assert property (@(posedge tck) disable iff (trst)
        (state == ST_RESET) |=> (ir == OP_IDCODE)); // R1

    AST_FIVE_ONES_HOME: assert property (@(posedge tck) disable iff (trst)
        (ones >= 3'd5) |-> (state == ST_RESET)); // R2

    AST_IR_MOVES_AT_UPDATE: assert property (@(posedge tck) disable iff (trst)
        !$stable(ir) |-> (state == ST_UPD_IR || state == ST_RESET)); // R3

    AST_FLOAT_NOT_DRIVE: assert property (@(posedge tck) disable iff (trst)
        !(force_hiz && drive_from_bsr)); // R7

    AST_LATCH_AT_UPDATE_DR: assert property (@(posedge tck) disable iff (trst)
        !$stable(bsr_out) |-> (state == ST_UPD_DR)); // R8

    AST_OE_IN_SHIFT: assert property (@(posedge tck) disable iff (trst)
        tdo_oe |-> (state == ST_SHF_DR || state == ST_SHF_IR)); // R9

endmodule

bind jtag_tap jtag_tap_chk #(.BSR_LEN(BSR_LEN)) u_chk (
    .tck            (tck),
    .trst           (trst),
    .tms            (tms),
    .state          (state_q),
    .ir             (ir_q),
    .tdo_oe         (tdo_oe),
    .bsr_out        (bsr_out),
    .drive_from_bsr (drive_from_bsr),
    .force_hiz      (force_hiz)
);

// File: tb/tb_jtag_tap.sv
`timescale 1ns/1ps
module tb_jtag_tap;

    localparam int          N      = 8;
    localparam logic [31:0] IDV    = 32'h1357_9BD4;
    localparam logic [31:0] ID_EXP = 32'h1357_9BD5;
    localparam logic [7:0]  MASK   = 8'hB6;
    localparam logic [7:0]  DFLT   = 8'h41;

    logic         tck = 1'b0;
    logic         trst = 1'b1;
    logic         tms = 1'b1;
    logic         tdi = 1'b0;
    logic [N-1:0] pins = '0;
    logic         tdo, tdo_oe, drive_from_bsr, force_hiz;
    logic [N-1:0] bsr_out;

    int n_chk = 0;
    int n_fail = 0;

    always #10 tck = ~tck; // 50 MHz

    jtag_tap #(
        .BSR_LEN (N), .ID_VALUE (IDV), .PIN_MASK (MASK), .CELL_DEFAULT (DFLT)
    ) dut (
        .tck (tck), .trst (trst), .tms (tms), .tdi (tdi), .pin_capture (pins),
        .tdo (tdo), .tdo_oe (tdo_oe), .bsr_out (bsr_out),
        .drive_from_bsr (drive_from_bsr), .force_hiz (force_hiz)
    );

    function automatic logic [7:0] cap_exp(input logic [7:0] p);
        return (p & MASK) | (DFLT & ~MASK);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input logic m, input logic d, output logic o);
        @(negedge tck);
        #2;
        o   = tdo;
        tms = m;
        tdi = d;
        @(posedge tck);
        #1;
    endtask

    task automatic go_idle();
        logic o;
        for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, o);
        tick(1'b0, 1'b0, o);
    endtask

    task automatic shift_ir(input logic [2:0] op, output logic [2:0] cap);
        logic o;
        tick(1'b1, 1'b0, o);
        tick(1'b1, 1'b0, o);
        tick(1'b0, 1'b0, o);
        tick(1'b0, 1'b0, o);
        for (int i = 0; i < 3; i++) tick(i == 2, op[i], cap[i]);
        tick(1'b1, 1'b0, o);
        tick(1'b0, 1'b0, o);
    endtask

    task automatic shift_dr(input int n, input logic [31:0] din, output logic [31:0] dout);
        logic o;
        dout = '0;
        tick(1'b1, 1'b0, o);
        tick(1'b0, 1'b0, o);
        tick(1'b0, 1'b0, o);
        for (int i = 0; i < n; i++) tick(i == n - 1, din[i], dout[i]);
        tick(1'b1, 1'b0, o);
        tick(1'b0, 1'b0, o);
    endtask

    task automatic t_reset_state();
        logic [31:0] d;
        trst = 1'b1;
        #25;
        check(!force_hiz && !drive_from_bsr, "R1 reset controls", {force_hiz, drive_from_bsr}, 0);
        check(tdo_oe == 1'b0, "R9 oe in reset", tdo_oe, 0);
        check(bsr_out == '0, "R8 latch at reset", bsr_out, 0);
        trst = 1'b0;
        go_idle();
        shift_dr(32, 32'h0, d);
        check(d == ID_EXP, "R1 R5 idcode after reset", d, ID_EXP);
    endtask

    task automatic t_ir_capture();
        logic [2:0] c;
        shift_ir(3'b111, c);
        check(c == 3'b001, "R3 IR capture pattern", c, 3'b001);
        shift_ir(3'b001, c);
    endtask

    task automatic t_bypass();
        logic [2:0]  c;
        logic [31:0] d;
        logic [2:0]  ops[4] = '{3'b011, 3'b101, 3'b110, 3'b111};
        for (int k = 0; k < 4; k++) begin
            shift_ir(ops[k], c);
            shift_dr(8, 32'h0000_00A7, d);
            check(d[7:0] == 8'h4E, "R4 bypass delay", {29'd0, ops[k]} << 8 | d[7:0], 8'h4E);
        end
    endtask

    task automatic t_tms_reset();
        logic [2:0]  c;
        logic [31:0] d;
        logic        o;
        shift_ir(3'b111, c);
        tick(1'b1, 1'b0, o);
        tick(1'b0, 1'b0, o);
        tick(1'b0, 1'b0, o);
        for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, o);
        tick(1'b0, 1'b0, o);
        shift_dr(32, 32'h0, d);
        check(d == ID_EXP, "R2 five TMS ones reload IDCODE", d, ID_EXP);
    endtask

    task automatic t_preload_extest();
        logic [2:0]  c;
        logic [31:0] d;
        pins = 8'h3C;
        shift_ir(3'b100, c);
        check(!drive_from_bsr && !force_hiz, "R8 sample leaves pins", {drive_from_bsr, force_hiz}, 0);
        shift_dr(N, 32'h5C, d);
        check(d[7:0] == cap_exp(8'h3C), "R6 sample capture", d[7:0], cap_exp(8'h3C));
        check(bsr_out == 8'h5C, "R8 preload latch", bsr_out, 8'h5C);
        pins = 8'hC3;
        shift_ir(3'b000, c);
        check(drive_from_bsr == 1'b1, "R8 extest drives", drive_from_bsr, 1);
        check(bsr_out == 8'h5C, "R8 latch kept over IR scan", bsr_out, 8'h5C);
        shift_dr(N, 32'h99, d);
        check(d[7:0] == cap_exp(8'hC3), "R6 extest capture", d[7:0], cap_exp(8'hC3));
        check(bsr_out == 8'h99, "R8 extest update", bsr_out, 8'h99);
    endtask

    task automatic t_float();
        logic [2:0]  c;
        logic [31:0] d;
        pins = 8'hFF;
        shift_ir(3'b010, c);
        check(force_hiz && !drive_from_bsr, "R7 float controls", {force_hiz, drive_from_bsr}, 2);
        shift_dr(N + 1, 32'h0, d);
        check(d[8:0] == {1'b0, cap_exp(8'hFF)}, "R7 R6 float selects boundary",
              d[8:0], {1'b0, cap_exp(8'hFF)});
    endtask

    task automatic t_oe_edge();
        logic [2:0] c;
        logic       o;
        shift_ir(3'b001, c);
        check(tdo_oe == 1'b0, "R9 oe low in idle", tdo_oe, 0);
        tick(1'b1, 1'b0, o);
        tick(1'b0, 1'b0, o);
        tick(1'b0, 1'b0, o);
        @(negedge tck);
        #2;
        check(tdo_oe == 1'b1 && tdo == 1'b1, "R9 first shift bit", {tdo_oe, tdo}, 3);
        tms = 1'b0;
        @(posedge tck);
        #1;
        check(tdo == 1'b1, "R9 tdo holds past rising edge", tdo, 1);
        @(negedge tck);
        #2;
        check(tdo == 1'b0, "R9 tdo moves on falling edge", tdo, 0);
        tms = 1'b1;
        @(posedge tck);
        #1;
        tick(1'b1, 1'b0, o);
        tick(1'b0, 1'b0, o);
        @(negedge tck);
        #2;
        check(tdo_oe == 1'b0, "R9 oe low after scan", tdo_oe, 0);
    endtask

    task automatic t_async_trst();
        logic [2:0]  c;
        logic [31:0] d;
        shift_ir(3'b010, c);
        @(negedge tck);
        #5;
        trst = 1'b1;
        #2;
        check(!force_hiz && !drive_from_bsr, "R10 async reset clears float",
              {force_hiz, drive_from_bsr}, 0);
        #20;
        trst = 1'b0;
        go_idle();
        shift_dr(32, 32'h0, d);
        check(d == ID_EXP, "R10 idcode after async reset", d, ID_EXP);
    endtask

    initial begin
        #(20 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset_state();
        t_ir_capture();
        t_bypass();
        t_tms_reset();
        t_preload_extest();
        t_float();
        t_oe_edge();
        t_async_trst();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule